// File: doc/BRIEF.md
# Firmware Hub Single-Byte Read Sequencer

This block is the host end of a 4-bit multiplexed firmware-hub bus, used for single-byte memory reads. A client raises a request that carries a 28-bit byte address and a 4-bit target select. The sequencer then drives one cycle on the bus:

- a start nibble, during which the frame strobe is low;
- the target select nibble;
- seven address nibbles;
- a size nibble.

After the size nibble it hands the bus to the target, polls the target's SYNC nibbles until the target reports ready, collects two data nibbles, and lets the target's closing turnaround finish. Only then does it return the byte with a one-clock acknowledge.

The bus appears as separate output, output-enable and input nibbles, so that a pad ring can merge them. A SYNC nibble that is neither ready nor wait aborts the cycle with an error. A wait-clock limit, which a port can program, does the same. A limit of zero lets the target stretch the cycle without bound. Only one cycle is outstanding at any time: the request level is looked at only while the sequencer is idle.

Top module: `fwh_read_host`

## Requirements
- R1: After synchronous reset, and in idle, `hub_frame_n` is 1, `hub_oe` is 0 and `ack` is 0.
- R2: The clock after a request is accepted is the start clock. In that clock `hub_frame_n` is 0, `hub_oe` is 1 and `hub_dout` equals START_CODE (default 4'b1101). `hub_frame_n` is low for that one clock only. The next clock drives the request's target nibble.
- R3: The next seven clocks drive the address nibbles: bits 27:24 first, then each lower nibble in turn, ending with bits 3:0. After the address comes one clock with `hub_dout` = 4'b0000, the single-byte size code.
- R4: The host then drives 4'b1111 with `hub_oe` = 1 for one clock and releases the bus (`hub_oe` = 0) on the following clock. `hub_oe` stays 0 from that clock through the acknowledge.
- R5: Each clock after the release, `hub_din` is sampled as SYNC. The value 4'b0101 means wait and the sequencer samples again on the next clock. The value 4'b0000 means ready. With `tmo_lim` = 0 there is no bound on the number of wait clocks.
- R6: The nibble sampled on the clock after the ready SYNC is `rd_data[3:0]`. The nibble sampled on the clock after that is `rd_data[7:4]`.
- R7: After the high data nibble come two clocks with `hub_oe` = 0 and `ack` = 0. On the next clock `ack` is 1 for exactly one clock, with `rd_err` = 0 and `rd_data` valid.
- R8: A SYNC value other than 4'b0000 or 4'b0101 ends the cycle: `ack` is 1 on the next clock with `rd_err` = 1, and no data phase follows.
- R9: With `tmo_lim` = N > 0, sampling the N-th consecutive 4'b0101 aborts the cycle: `ack` is 1 on the next clock with `rd_err` = 1. N-1 waits followed by a ready complete normally.
- R10: `req` is ignored while a cycle is in progress. If `req` is held high, the clock after `ack` is idle and the next start clock follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request level, taken only when idle |
| req_addr | input | 28 | Byte address of the read |
| req_tgt | input | 4 | Target select nibble |
| tmo_lim | input | 16 | Wait-clock limit; 0 disables the limit |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte read, valid with ack |
| rd_err | output | 1 | Cycle aborted (bad SYNC or timeout), valid with ack |
| hub_frame_n | output | 1 | Active-low frame strobe |
| hub_dout | output | 4 | Nibble driven toward the bus |
| hub_oe | output | 1 | Output enable for hub_dout |
| hub_din | input | 4 | Nibble sampled from the bus |

## Verification
Reads are tried with:

- address and target patterns (alternating, all-ones, single set bit at either end) that expose a reversed or shifted nibble order;
- data bytes with distinct low and high nibbles, which separate a swapped byte assembly from a correct one;
- SYNC sequences with zero, a few and twenty waits, under no limit and under a limit one above the wait count, which separate a premature timeout from a working wait loop;
- wait runs that reach the limit exactly, and two different illegal SYNC codes, which check that the abort falls on the right clock and raises the error.

A held request confirms that no second start appears before the acknowledge.

// File: rtl/fwh_rd_pkg.sv
package fwh_rd_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_IDSEL,
        PH_ADDR,
        PH_SIZE,
        PH_HTAR_HI,
        PH_HTAR_Z,
        PH_SYNC,
        PH_DLO,
        PH_DHI,
        PH_TTAR_A,
        PH_TTAR_B,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        SY_READY,
        SY_WAIT,
        SY_BAD
    } sync_e;

    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_WAIT  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_TAR    = 4'b1111;
    localparam logic [NIB_W-1:0] SIZE_BYTE  = 4'b0000;

    function automatic sync_e classify_sync(logic [NIB_W-1:0] n);
        if (n == SYNC_READY)     return SY_READY;
        else if (n == SYNC_WAIT) return SY_WAIT;
        else                     return SY_BAD;
    endfunction

endpackage

// File: rtl/fwh_rd_timer.sv
module fwh_rd_timer
    import fwh_rd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [TMO_W-1:0] lim,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   next_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    always_comb begin
        next_cnt = {1'b0, cnt} + 1'b1;
        expired  = tick && (lim != '0) && (next_cnt == {1'b0, lim});
    end

endmodule

// File: rtl/fwh_rd_ctrl.sv
module fwh_rd_ctrl
    import fwh_rd_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [NIB_W-1:0] din,
    input  logic             expired,
    output phase_e           ph,
    output logic [IDX_W-1:0] nib_idx,
    output logic             accept,
    output logic             wait_tick,
    output logic             sync_clr,
    output logic             fail,
    output logic             cap_lo,
    output logic             cap_hi
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_NIBS - 1);

    sync_e cls;

    always_comb begin
        cls       = classify_sync(din);
        accept    = (ph == PH_IDLE) && req;
        wait_tick = (ph == PH_SYNC) && (cls == SY_WAIT);
        sync_clr  = (ph != PH_SYNC);
        fail      = (ph == PH_SYNC) &&
                    ((cls == SY_BAD) || ((cls == SY_WAIT) && expired));
        cap_lo    = (ph == PH_DLO);
        cap_hi    = (ph == PH_DHI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            nib_idx <= '0;
        end else begin
            case (ph)
                PH_IDLE:    if (req) ph <= PH_START;
                PH_START:   ph <= PH_IDSEL;
                PH_IDSEL: begin
                    ph      <= PH_ADDR;
                    nib_idx <= '0;
                end
                PH_ADDR: begin
                    if (nib_idx == LAST_IDX) ph <= PH_SIZE;
                    else nib_idx <= nib_idx + 1'b1;
                end
                PH_SIZE:    ph <= PH_HTAR_HI;
                PH_HTAR_HI: ph <= PH_HTAR_Z;
                PH_HTAR_Z:  ph <= PH_SYNC;
                PH_SYNC: begin
                    case (cls)
                        SY_READY: ph <= PH_DLO;
                        SY_WAIT:  if (expired) ph <= PH_DONE;
                        default:  ph <= PH_DONE;
                    endcase
                end
                PH_DLO:     ph <= PH_DHI;
                PH_DHI:     ph <= PH_TTAR_A;
                PH_TTAR_A:  ph <= PH_TTAR_B;
                PH_TTAR_B:  ph <= PH_DONE;
                PH_DONE:    ph <= PH_IDLE;
                default:    ph <= PH_IDLE;
            endcase
        end
    end

    // R8: an illegal SYNC nibble leads straight to completion
    assert_bad_sync_R8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SYNC && cls == SY_BAD) |=> (ph == PH_DONE));

    // R9: an expired wait limit leads straight to completion
    assert_timeout_abort_R9: assert property (@(posedge clk) disable iff (rst)
        expired |=> (ph == PH_DONE));

endmodule

// File: rtl/fwh_rd_drv.sv
module fwh_rd_drv
    import fwh_rd_pkg::*;
#(
    parameter int               ADDR_W     = 28,
    parameter int               ADDR_NIBS  = 7,
    parameter int               IDX_W      = 3,
    parameter logic [NIB_W-1:0] START_CODE = 4'b1101
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph,
    input  logic [IDX_W-1:0]  nib_idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  tgt,
    output logic              frame_n,
    output logic [NIB_W-1:0]  dout,
    output logic              oe
);
    logic [NIB_W-1:0] addr_nib;

    always_comb begin
        addr_nib = NIB_TAR;
        for (int k = 0; k < ADDR_NIBS; k++) begin
            if (nib_idx == IDX_W'(k))
                addr_nib = addr[ADDR_W-1-NIB_W*k -: NIB_W];
        end
    end

    always_comb begin
        frame_n = 1'b1;
        oe      = 1'b0;
        dout    = NIB_TAR;
        case (ph)
            PH_START: begin
                frame_n = 1'b0;
                oe      = 1'b1;
                dout    = START_CODE;
            end
            PH_IDSEL: begin
                oe   = 1'b1;
                dout = tgt;
            end
            PH_ADDR: begin
                oe   = 1'b1;
                dout = addr_nib;
            end
            PH_SIZE: begin
                oe   = 1'b1;
                dout = SIZE_BYTE;
            end
            PH_HTAR_HI: begin
                oe   = 1'b1;
                dout = NIB_TAR;
            end
            default: begin
                oe   = 1'b0;
                dout = NIB_TAR;
            end
        endcase
    end

    // R2: the frame strobe is low for exactly one clock
    assert_frame_one_clk_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (frame_n && oe));

    // R4: the host lets go of the bus right after driving 1111
    assert_tar_release_R4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HTAR_HI) |=> !oe);

endmodule

// File: rtl/fwh_rd_cap.sv
module fwh_rd_cap
    import fwh_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             fail,
    input  logic             cap_lo,
    input  logic             cap_hi,
    input  logic [NIB_W-1:0] din,
    output logic [7:0]       data,
    output logic             err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            err  <= 1'b0;
        end else begin
            if (cap_lo) data[3:0] <= din;
            if (cap_hi) data[7:4] <= din;
            if (accept)    err <= 1'b0;
            else if (fail) err <= 1'b1;
        end
    end

endmodule

// File: rtl/fwh_read_host.sv
module fwh_read_host
    import fwh_rd_pkg::*;
#(
    parameter int               ADDR_W     = 28,
    parameter int               TMO_W      = 16,
    parameter logic [3:0]       START_CODE = 4'b1101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_tgt,
    input  logic [TMO_W-1:0]  tmo_lim,
    output logic              ack,
    output logic [7:0]        rd_data,
    output logic              rd_err,
    output logic              hub_frame_n,
    output logic [3:0]        hub_dout,
    output logic              hub_oe,
    input  logic [3:0]        hub_din
);
    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int IDX_W     = $clog2(ADDR_NIBS);

    phase_e            ph;
    logic [IDX_W-1:0]  nib_idx;
    logic              accept, wait_tick, sync_clr, fail, cap_lo, cap_hi, expired;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            tgt_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            tgt_q  <= req_tgt;
        end
    end

    fwh_rd_ctrl #(.ADDR_NIBS(ADDR_NIBS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .din(hub_din), .expired(expired),
        .ph(ph), .nib_idx(nib_idx), .accept(accept), .wait_tick(wait_tick),
        .sync_clr(sync_clr), .fail(fail), .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    fwh_rd_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .clr(sync_clr), .tick(wait_tick),
        .lim(tmo_lim), .expired(expired)
    );

    fwh_rd_drv #(.ADDR_W(ADDR_W), .ADDR_NIBS(ADDR_NIBS), .IDX_W(IDX_W),
                 .START_CODE(START_CODE)) u_drv (
        .clk(clk), .rst(rst), .ph(ph), .nib_idx(nib_idx), .addr(addr_q),
        .tgt(tgt_q), .frame_n(hub_frame_n), .dout(hub_dout), .oe(hub_oe)
    );

    fwh_rd_cap u_cap (
        .clk(clk), .rst(rst), .accept(accept), .fail(fail), .cap_lo(cap_lo),
        .cap_hi(cap_hi), .din(hub_din), .data(rd_data), .err(rd_err)
    );

    assign ack = (ph == PH_DONE);

    // R7: completion is a single-clock pulse
    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R4: the host never drives the bus while acknowledging
    assert_ack_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ack |-> !hub_oe);

    // R7: two released clocks follow the high data nibble
    assert_target_tar_R7: assert property (@(posedge clk) disable iff (rst)
        cap_hi |=> !hub_oe ##1 !hub_oe);

    // R10: no new start can follow an acknowledge directly
    assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> hub_frame_n);

endmodule

// File: tb/fwh_read_host_test.sv
`timescale 1ns/1ps
module fwh_read_host_test;

    typedef struct packed {
        logic [27:0] addr;
        logic [3:0]  tgt;
        logic [7:0]  waits;
        logic [1:0]  kind;   // 0 ok, 1 bad sync code, 2 timeout
        logic [3:0]  bad;
        logic [7:0]  data;
        logic [15:0] lim;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{28'h1234567, 4'h0, 8'd0,  2'd0, 4'h0, 8'hA5, 16'd0},
        '{28'hFEDCBA9, 4'hF, 8'd3,  2'd0, 4'h0, 8'h3C, 16'd0},
        '{28'h0000001, 4'h5, 8'd20, 2'd0, 4'h0, 8'hFF, 16'd0},
        '{28'h8000000, 4'h9, 8'd2,  2'd0, 4'h0, 8'h00, 16'd3},
        '{28'h5A5A5A5, 4'h2, 8'd4,  2'd2, 4'h0, 8'h00, 16'd4},
        '{28'h0F0F0F0, 4'h7, 8'd1,  2'd1, 4'hA, 8'h00, 16'd0},
        '{28'hC3C3C3C, 4'h1, 8'd0,  2'd1, 4'h6, 8'h00, 16'd0},
        '{28'hFFFFFFF, 4'hE, 8'd1,  2'd0, 4'h0, 8'h5A, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [27:0] req_addr = '0;
    logic [3:0]  req_tgt = '0;
    logic [15:0] tmo_lim = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic        rd_err;
    logic        hub_frame_n;
    logic [3:0]  hub_dout;
    logic        hub_oe;
    logic [3:0]  hub_din = 4'hF;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fwh_read_host uut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_tgt(req_tgt),
        .tmo_lim(tmo_lim), .ack(ack), .rd_data(rd_data), .rd_err(rd_err),
        .hub_frame_n(hub_frame_n), .hub_dout(hub_dout), .hub_oe(hub_oe),
        .hub_din(hub_din)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(hub_frame_n === 1'b1, {tag, " frame_n"}, 32'(hub_frame_n), 1);
        chk(hub_oe === 1'b0, {tag, " oe"}, 32'(hub_oe), 0);
        chk(ack === 1'b0, {tag, " ack"}, 32'(ack), 0);
    endtask

    task automatic run_read(input vec_t v, input logic hold);
        @(negedge clk);
        req = 1'b1; req_addr = v.addr; req_tgt = v.tgt; tmo_lim = v.lim;
        @(negedge clk);  // start clock
        chk(hub_frame_n == 1'b0 && hub_oe == 1'b1, "R2 start frame/oe",
            {30'd0, hub_frame_n, hub_oe}, 32'd1);
        chk(hub_dout == 4'hD, "R2 start code", 32'(hub_dout), 32'hD);
        if (!hold) req = 1'b0;
        @(negedge clk);
        chk(hub_frame_n == 1'b1, "R2 frame single clock", 32'(hub_frame_n), 1);
        chk(hub_oe && hub_dout == v.tgt, "R2 target nibble", 32'(hub_dout), 32'(v.tgt));
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk(hub_oe && hub_dout == v.addr[27-4*k -: 4], "R3 address nibble",
                32'(hub_dout), 32'(v.addr[27-4*k -: 4]));
        end
        @(negedge clk);
        chk(hub_oe && hub_dout == 4'h0, "R3 size nibble", 32'(hub_dout), 0);
        @(negedge clk);
        chk(hub_oe && hub_dout == 4'hF, "R4 turnaround 1111", 32'(hub_dout), 32'hF);
        @(negedge clk);
        chk(hub_oe == 1'b0, "R4 bus released", 32'(hub_oe), 0);
        for (int i = 0; i < int'(v.waits); i++) begin
            @(negedge clk);
            chk(!hub_oe && !ack && hub_frame_n, "R5 wait clock quiet (R10 no restart)",
                {29'd0, hub_oe, ack, hub_frame_n}, 32'd1);
            hub_din = 4'b0101;
        end
        if (v.kind == 2'd2) begin
            @(negedge clk);
            hub_din = 4'hF;
            chk(ack && rd_err, "R9 timeout abort", {30'd0, ack, rd_err}, 32'd3);
        end else if (v.kind == 2'd1) begin
            @(negedge clk);
            hub_din = v.bad;
            @(negedge clk);
            hub_din = 4'hF;
            chk(ack && rd_err, "R8 bad sync abort", {30'd0, ack, rd_err}, 32'd3);
        end else begin
            @(negedge clk);
            hub_din = 4'b0000;
            @(negedge clk);
            hub_din = v.data[3:0];
            @(negedge clk);
            hub_din = v.data[7:4];
            @(negedge clk);
            chk(!hub_oe && !ack, "R7 target turnaround 1", {30'd0, hub_oe, ack}, 0);
            hub_din = 4'hF;
            @(negedge clk);
            chk(!hub_oe && !ack, "R7 target turnaround 2", {30'd0, hub_oe, ack}, 0);
            @(negedge clk);
            chk(ack && !rd_err && !hub_oe, "R7 ack ok (R5 after waits)",
                {29'd0, ack, rd_err, hub_oe}, 32'd4);
            chk(rd_data == v.data, "R6 byte assembly", 32'(rd_data), 32'(v.data));
        end
        @(negedge clk);
        chk(ack == 1'b0, "R7 ack single clock", 32'(ack), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        idle_chk("R1 reset state");

        for (int n = 0; n < NV; n++) run_read(VECS[n], 1'b0);

        // R10: request held high through a whole cycle
        run_read(VECS[1], 1'b1);
        chk(hub_frame_n == 1'b1, "R10 idle clock after ack", 32'(hub_frame_n), 1);
        @(negedge clk);
        chk(hub_frame_n == 1'b0 && hub_dout == 4'hD, "R10 next start",
            {27'd0, hub_frame_n, hub_dout}, 32'hD);
        req = 1'b0;

        // R1: reset in the middle of a cycle returns to idle
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_chk("R1 reset mid-cycle");
        repeat (3) @(negedge clk);
        idle_chk("R1 stays idle without req");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule